// File: doc/BRIEF.md
# Clock Generator Control Register Bank

This block is the register file that sits behind the command decoder of a two-wire serial slave. It exposes a byte-wide write port and a combinational read port, both addressed by byte. It holds the settings of a line-locked clock generator: a 12-bit line-length divider, an oscillator range code, a charge pump current code and a sampling phase code. It also holds the position and the width of an internally generated clamp pulse, and address zero returns a fixed silicon revision byte.

The divider is spread over two addresses. Address 0x01 holds its upper eight bits and bits 7-4 of address 0x02 hold its lower four bits. The clocking logic does not use the stored bits directly. It uses a separate committed copy, and that copy is loaded as one 12-bit value only when the low-order address is written. Software can therefore change the upper byte first, and the clock generator sees a single step once the low nibble arrives. A one-cycle strobe marks each load. The block also supplies the effective division ratio, which is the committed value plus one.

The asynchronous active-low reset is released through a two-stage synchronizer, so the registers leave reset two clock edges after the reset input rises.

Top module: `clkgen_ctrl_regs`

## Requirements
- R1: Address 0x00 reads the REVISION parameter (default 0x01). A write to address 0x00 changes no output and no readback value.
- R2: Out of reset the committed divider is 1693, with upper byte 0x69 and lower nibble 0xD. The range code is 2'b01, the pump code is 3'b001, the phase code is 16, clamp placement is 0x08, clamp duration is 0x14 and the commit strobe is low.
- R3: A write to address 0x01 updates only the stored upper byte. The committed divider does not change and the strobe stays low.
- R4: A write to address 0x02 with data D loads the committed divider with {stored upper byte, D[7:4]} in the cycle after the write, and the strobe is high for exactly that cycle. The strobe is never high at any other time.
- R5: Reads of addresses 0x01 to 0x06 return the stored register contents, not the committed divider copy.
- R6: Bits with no field read as zero and ignore writes: 0x02 bits 3-0, 0x03 bits 2-0 and 0x04 bits 2-0. Addresses above 0x06 read 0x00, and writes to them have no effect.
- R7: The range code output is bits 7-6 of address 0x03, the pump code output is bits 5-3 of address 0x03, and the phase code output is bits 7-3 of address 0x04. Each follows a write in the next cycle.
- R8: The clamp placement output is the byte at address 0x05 and the clamp duration output is the byte at address 0x06. Each follows a write in the next cycle.
- R9: The ratio output always equals the committed divider plus one, as a 13-bit value, so a committed value of 0xFFF gives 4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for one cycle |
| addr_i | input | 8 | Byte address for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data at addr_i |
| div_value_o | output | 12 | Committed divider value |
| div_ratio_o | output | 13 | Committed divider plus one |
| div_commit_o | output | 1 | One-cycle pulse when the divider is loaded |
| vco_range_o | output | 2 | Oscillator range code |
| pump_cur_o | output | 3 | Charge pump current code |
| phase_o | output | 5 | Sampling phase code, 11.25 degrees per step |
| clamp_place_o | output | 8 | Clamp start, in pixels after the sync edge |
| clamp_dur_o | output | 8 | Clamp length in pixels |

## Verification
Some properties are checked by assertions on every cycle. The strobe may rise only after a low-order write. The committed divider holds its value in every cycle that follows no such write, and after a commit it equals the staged byte joined with the written nibble. The ratio stays one above the divider, each field keeps its value when it is not written, and unmapped addresses read zero.

Other behaviour only the bench scenarios can show. These are the reset values, the split between the stored upper byte and the committed copy when the two writes are far apart, rejected writes to the revision address and to unmapped addresses, masking of bits with no field, and the boundary divider values.

// File: rtl/ckr_pkg.sv
package ckr_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned DIV_W  = 12;
  localparam int unsigned DIV_HI_W = 8;
  localparam int unsigned DIV_LO_W = DIV_W - DIV_HI_W;
  localparam int unsigned RANGE_W = 2;
  localparam int unsigned PUMP_W  = 3;
  localparam int unsigned PHASE_W = 5;

  localparam logic [ADDR_W-1:0] A_REV   = 8'h00;
  localparam logic [ADDR_W-1:0] A_DIVHI = 8'h01;
  localparam logic [ADDR_W-1:0] A_DIVLO = 8'h02;
  localparam logic [ADDR_W-1:0] A_CLKG  = 8'h03;
  localparam logic [ADDR_W-1:0] A_PHASE = 8'h04;
  localparam logic [ADDR_W-1:0] A_CPLC  = 8'h05;
  localparam logic [ADDR_W-1:0] A_CDUR  = 8'h06;
  localparam int unsigned FIRST_WR = 1;
  localparam int unsigned LAST_WR  = 6;

  localparam logic [DIV_W-1:0]   RST_DIV   = 12'd1693;
  localparam logic [RANGE_W-1:0] RST_RANGE = 2'b01;
  localparam logic [PUMP_W-1:0]  RST_PUMP  = 3'b001;
  localparam logic [PHASE_W-1:0] RST_PHASE = 5'd16;
  localparam logic [DATA_W-1:0]  RST_CPLC  = 8'h08;
  localparam logic [DATA_W-1:0]  RST_CDUR  = 8'h14;
endpackage

// File: rtl/ckr_wr_decode.sv
module ckr_wr_decode #(
  parameter int unsigned AW = 8,
  parameter int unsigned LO = 1,
  parameter int unsigned HI = 6
) (
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  output logic [HI:LO]  sel_o
);
  for (genvar i = LO; i <= HI; i++) begin : g_sel
    assign sel_o[i] = wr_en_i && (addr_i == AW'(i));
  end
endmodule

// File: rtl/ckr_field_reg.sv
module ckr_field_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d, q_q;

  always_comb begin
    q_d = q_q;
    if (en_i) q_d = d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= RST_VAL;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  // R6: an unwritten field keeps its value
  p_field_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));
endmodule

// File: rtl/ckr_div_stage.sv
module ckr_div_stage #(
  parameter int unsigned DW  = 8,
  parameter int unsigned HW  = 8,
  parameter int unsigned LW  = 4,
  parameter logic [HW+LW-1:0] RST_VAL = '0,
  localparam int unsigned VW = HW + LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hi_wr_i,
  input  logic          lo_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [HW-1:0] hi_q_o,
  output logic [LW-1:0] lo_q_o,
  output logic [VW-1:0] div_o,
  output logic [VW:0]   ratio_o,
  output logic          commit_o
);
  logic [LW-1:0] lo_new;
  logic [VW-1:0] div_d, div_q;
  logic [VW:0]   ratio_d, ratio_q;
  logic          commit_d, commit_q;

  assign lo_new = wdata_i[DW-1 -: LW];

  ckr_field_reg #(.W(HW), .RST_VAL(RST_VAL[VW-1 -: HW])) u_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(hi_wr_i),
    .d_i(wdata_i[DW-1 -: HW]), .q_o(hi_q_o));

  ckr_field_reg #(.W(LW), .RST_VAL(RST_VAL[LW-1:0])) u_lo (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(lo_wr_i),
    .d_i(lo_new), .q_o(lo_q_o));

  always_comb begin
    div_d    = div_q;
    ratio_d  = ratio_q;
    commit_d = 1'b0;
    if (lo_wr_i) begin
      div_d    = {hi_q_o, lo_new};
      ratio_d  = {1'b0, hi_q_o, lo_new} + (VW+1)'(1);
      commit_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q    <= RST_VAL;
      ratio_q  <= {1'b0, RST_VAL} + (VW+1)'(1);
      commit_q <= 1'b0;
    end else begin
      div_q    <= div_d;
      ratio_q  <= ratio_d;
      commit_q <= commit_d;
    end
  end

  assign div_o    = div_q;
  assign ratio_o  = ratio_q;
  assign commit_o = commit_q;

  // R4: the strobe only follows a low-order write
  p_commit_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(lo_wr_i));
  // R4: the committed value joins the staged byte and the new nibble
  p_commit_val_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_wr_i |=> div_o == {$past(hi_q_o), $past(lo_new)});
  // R3: without a low-order write the committed divider holds
  p_div_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lo_wr_i |=> $stable(div_o));
  // R9: the ratio stays one above the divider
  p_ratio_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_o == {1'b0, div_o} + (VW+1)'(1));
endmodule

// File: rtl/clkgen_ctrl_regs.sv
module clkgen_ctrl_regs
  import ckr_pkg::*;
#(
  parameter logic [DATA_W-1:0] REVISION = 8'h01
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [DIV_W-1:0]    div_value_o,
  output logic [DIV_W:0]      div_ratio_o,
  output logic                div_commit_o,
  output logic [RANGE_W-1:0]  vco_range_o,
  output logic [PUMP_W-1:0]   pump_cur_o,
  output logic [PHASE_W-1:0]  phase_o,
  output logic [DATA_W-1:0]   clamp_place_o,
  output logic [DATA_W-1:0]   clamp_dur_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  logic [LAST_WR:FIRST_WR] sel;
  ckr_wr_decode #(.AW(ADDR_W), .LO(FIRST_WR), .HI(LAST_WR)) u_dec (
    .wr_en_i(wr_en_i), .addr_i(addr_i), .sel_o(sel));

  logic [DIV_HI_W-1:0] div_hi;
  logic [DIV_LO_W-1:0] div_lo;

  ckr_div_stage #(.DW(DATA_W), .HW(DIV_HI_W), .LW(DIV_LO_W), .RST_VAL(RST_DIV)) u_div (
    .clk_i(clk_i), .rst_ni(rst_n),
    .hi_wr_i(sel[int'(A_DIVHI)]), .lo_wr_i(sel[int'(A_DIVLO)]),
    .wdata_i(wdata_i), .hi_q_o(div_hi), .lo_q_o(div_lo),
    .div_o(div_value_o), .ratio_o(div_ratio_o), .commit_o(div_commit_o));

  ckr_field_reg #(.W(RANGE_W), .RST_VAL(RST_RANGE)) u_range (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(sel[int'(A_CLKG)]),
    .d_i(wdata_i[7:6]), .q_o(vco_range_o));

  ckr_field_reg #(.W(PUMP_W), .RST_VAL(RST_PUMP)) u_pump (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(sel[int'(A_CLKG)]),
    .d_i(wdata_i[5:3]), .q_o(pump_cur_o));

  ckr_field_reg #(.W(PHASE_W), .RST_VAL(RST_PHASE)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(sel[int'(A_PHASE)]),
    .d_i(wdata_i[7:3]), .q_o(phase_o));

  ckr_field_reg #(.W(DATA_W), .RST_VAL(RST_CPLC)) u_cplc (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(sel[int'(A_CPLC)]),
    .d_i(wdata_i), .q_o(clamp_place_o));

  ckr_field_reg #(.W(DATA_W), .RST_VAL(RST_CDUR)) u_cdur (
    .clk_i(clk_i), .rst_ni(rst_n), .en_i(sel[int'(A_CDUR)]),
    .d_i(wdata_i), .q_o(clamp_dur_o));

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_REV:   rdata_o = REVISION;
      A_DIVHI: rdata_o = div_hi;
      A_DIVLO: rdata_o = {div_lo, {(DATA_W-DIV_LO_W){1'b0}}};
      A_CLKG:  rdata_o = {vco_range_o, pump_cur_o, {(DATA_W-RANGE_W-PUMP_W){1'b0}}};
      A_PHASE: rdata_o = {phase_o, {(DATA_W-PHASE_W){1'b0}}};
      A_CPLC:  rdata_o = clamp_place_o;
      A_CDUR:  rdata_o = clamp_dur_o;
      default: rdata_o = '0;
    endcase
  end

  // R6: addresses above the map read zero
  p_unmapped_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (addr_i > A_CDUR) |-> (rdata_o == '0));
  // R1: the revision address returns the fixed byte
  p_rev_fixed_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (addr_i == A_REV) |-> (rdata_o == REVISION));
endmodule

// File: tb/clkgen_ctrl_regs_tb_top.sv
`timescale 1ns/1ps
module clkgen_ctrl_regs_tb_top;
  localparam logic [7:0] REV = 8'h01;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [11:0] div_v;
  logic [12:0] ratio;
  logic commit;
  logic [1:0] rng;
  logic [2:0] pump;
  logic [4:0] phase;
  logic [7:0] cplc, cdur;

  always #10 clk = ~clk;

  clkgen_ctrl_regs #(.REVISION(REV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .div_value_o(div_v), .div_ratio_o(ratio),
    .div_commit_o(commit), .vco_range_o(rng), .pump_cur_o(pump),
    .phase_o(phase), .clamp_place_o(cplc), .clamp_dur_o(cdur));

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // behavioural reference: byte image of the map plus committed divider
  int m_reg[7];
  int m_div;
  bit m_commit;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg[0] <= REV; m_reg[1] <= 'h69; m_reg[2] <= 'hD0; m_reg[3] <= 'h48;
      m_reg[4] <= 'h80; m_reg[5] <= 'h08; m_reg[6] <= 'h14;
      m_div <= 1693; m_commit <= 0;
    end else begin
      m_commit <= 0;
      if (wr) begin
        case (addr)
          1: m_reg[1] <= wdata;
          2: begin
               m_reg[2] <= wdata & 'hF0;
               m_div <= m_reg[1] * 16 + wdata / 16;
               m_commit <= 1;
             end
          3: m_reg[3] <= wdata & 'hF8;
          4: m_reg[4] <= wdata & 'hF8;
          5: m_reg[5] <= wdata;
          6: m_reg[6] <= wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (addr == 0)      chk("R1 rdata", rdata, REV);
      else if (addr <= 6) chk("R5 rdata", rdata, m_reg[addr]);
      else                chk("R6 rdata", rdata, 0);
      chk("R4 div", div_v, m_div);
      chk("R4 commit", commit, m_commit);
      chk("R9 ratio", ratio, m_div + 1);
      chk("R7 range", rng, m_reg[3] / 64);
      chk("R7 pump", pump, (m_reg[3] / 8) % 8);
      chk("R7 phase", phase, m_reg[4] / 8);
      chk("R8 place", cplc, m_reg[5]);
      chk("R8 dur", cdur, m_reg[6]);
    end
  end

  task automatic step(bit w, int a, int d);
    @(posedge clk); #2;
    wr = w; addr = 8'(a); wdata = 8'(d);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) step(0, 0, 0);
    // R2: reset values against constants
    @(negedge clk);
    chk("R2 div", div_v, 1693);
    chk("R2 ratio", ratio, 1694);
    chk("R2 range", rng, 1);
    chk("R2 pump", pump, 1);
    chk("R2 phase", phase, 16);
    chk("R2 place", cplc, 8);
    chk("R2 dur", cdur, 20);
    chk("R2 commit", commit, 0);
    for (int a = 0; a < 9; a++) step(0, a, 0);
    // R1: revision write discarded
    step(1, 0, 'hA5); step(0, 0, 0);
    // R3: upper byte alone is staged, committed copy unchanged
    step(1, 1, 'h12); step(0, 1, 0); step(0, 2, 0);
    repeat (3) step(0, 1, 0);
    @(negedge clk);
    chk("R3 div held", div_v, 1693);
    chk("R5 staged readback", rdata, 'h12);
    // R4: low-order write commits
    step(1, 2, 'h7F); step(0, 2, 0); step(0, 2, 0);
    @(negedge clk);
    chk("R4 div committed", div_v, 'h127);
    // R6: unused bits and unmapped addresses
    step(1, 3, 'hFF); step(0, 3, 0);
    step(1, 4, 'hFF); step(0, 4, 0);
    step(1, 7, 'hFF); step(0, 7, 0);
    step(1, 'hFF, 'hFF); step(0, 'hFF, 0);
    // R9 boundaries
    step(1, 1, 'hFF); step(1, 2, 'hF0); step(0, 2, 0);
    @(negedge clk);
    chk("R9 ratio 4096", ratio, 4096);
    step(1, 1, 'h00); step(1, 2, 'h10); step(0, 1, 0);
    @(negedge clk);
    chk("R9 ratio 2", ratio, 2);
    // back-to-back low-order writes
    step(1, 2, 'h30); step(1, 2, 'h40); step(0, 2, 0);
    // R7 R8: mixed traffic
    for (int i = 0; i < 300; i++) step($urandom_range(0, 1), $urandom_range(0, 9), $urandom_range(0, 255));
    step(0, 0, 0); step(0, 0, 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule